// File: doc/BRIEF.md
# Freezable Clock-Calendar Register Bank

This block is the eight-byte clock window that sits at the top of a byte-wide memory map. A host reads and writes it like RAM through a synchronous port with a chip-select, a write-enable, a 3-bit offset and separate 8-bit write and read data buses. Inside, a packed-BCD counter holds seconds through years in 24-hour form. It advances on a one-second tick input, and its value is copied into the host-visible bytes on the cycle after each tick.

Two bits in the control byte stop that copying. The read-freeze bit holds a stable snapshot while the counter keeps running. The set-freeze bit lets the host write a new time into the visible bytes. Clearing the set-freeze bit loads those bytes into the counter. An oscillator-stop bit in the seconds byte halts the counter entirely, and it comes out of reset set. Bits that carry no time field are plain storage.

Top module: `rtc_regbank`

## Requirements
- R1: Offsets map as 0 control, 1 seconds, 2 minutes, 3 hours, 4 day-of-week, 5 date, 6 month and 7 year. A read (cs=1, we=0) presents the addressed byte on `rdata` after the next clock edge. `rdata` holds its value in every cycle without a read.
- R2: After reset the bytes read control 00h, seconds 80h, minutes 00h, hours 00h, day 01h, date 01h, month 01h and year 00h.
- R3: While seconds bit 7 (oscillator stop) is 1, ticks neither advance the counter nor refresh the visible bytes. Once the bit is 0, the next tick refreshes them.
- R4: Each tick while running adds one second in BCD with carries. Seconds and minutes wrap 59h to 00h, hours wrap 23h to 00h, and day-of-week wraps 07h to 01h at midnight.
- R5: Date wraps to 01h after the last day of the month: 30h for months 04h, 06h, 09h and 11h, 31h for the others, and 28h for month 02h, or 29h when the year value is divisible by 4. Month wraps 12h to 01h, and year wraps 99h to 00h.
- R6: A tick taken while both freeze bits are 0 and the oscillator runs updates all seven time bytes on the following edge. Only the time fields change: seconds and minutes bits 6:0, hours and date bits 5:0, day bits 2:0, month bits 4:0 and year bits 7:0.
- R7: While control bit 6 (read freeze) is 1, no refresh takes place, but the counter keeps advancing. After the bit clears, the next tick shows the time including all ticks taken while frozen.
- R8: A tick sampled while both freeze bits are 0 commits its refresh. A control write that sets a freeze bit on the tick edge or on the following edge does not cancel that refresh.
- R9: While control bit 7 (set freeze) is 1, no refresh takes place and host writes to the time bytes persist. A control write with bit 7 = 0 while bit 7 is 1 loads the time fields into the counter on that edge, and a load takes priority over a tick on the same edge.
- R10: Non-time bits (control bits 5:0, the upper non-field bits of the time bytes) read back as written and survive refreshes.
- R11: A host write to a time byte on the edge where a refresh lands keeps the host value for that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cs | input | 1 | Register access select |
| we | input | 1 | 1 = write, 0 = read when cs=1 |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after a read |

## Verification
Two pairs of functions can meet on the same edge. The first is a freeze request and a refresh that is already committed. The second is a host write to a time byte and the refresh copy. The bench provokes both by driving the tick and a control write in the same cycle, and by driving a control write or a minutes write in the cycle just after the tick. It then reads the bytes back: a committed refresh must still land, the host's byte must win, and later ticks must stay frozen or overwrite the host value as the rules say.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int DW   = 8;
  localparam int NREG = 8;
  localparam int AW   = $clog2(NREG);
  localparam int TW   = (NREG - 1) * DW;

  localparam logic [AW-1:0] OFS_CTRL = 3'd0;
  localparam int CTL_SET_BIT  = 7;
  localparam int CTL_HOLD_BIT = 6;
  localparam int OSC_STOP_BIT = 7;

  typedef struct packed {
    logic [DW-1:0] yr;
    logic [DW-1:0] mon;
    logic [DW-1:0] date;
    logic [DW-1:0] dow;
    logic [DW-1:0] hr;
    logic [DW-1:0] min;
    logic [DW-1:0] sec;
  } rtc_time_t;

  function automatic logic [DW-1:0] field_mask(input int idx);
    case (idx)
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_byte(input int idx);
    case (idx)
      1:       return 8'h80;
      4, 5, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [TW-1:0] time_mask();
    logic [TW-1:0] m;
    for (int i = 1; i < NREG; i++) m[(i-1)*DW +: DW] = field_mask(i);
    return m;
  endfunction

  function automatic logic [DW-1:0] bcd_step(input logic [DW-1:0] v,
                                             input logic [DW-1:0] top,
                                             input logic [DW-1:0] bottom);
    if (v == top)          return bottom;
    else if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'h0};
    else                   return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [DW-1:0] month_len(input logic [DW-1:0] mon,
                                              input logic [DW-1:0] yr);
    logic [DW-1:0] bin;
    bin = {4'h0, yr[7:4]} * 8'd10 + {4'h0, yr[3:0]};
    case (mon)
      8'h02:                      return (bin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_regbank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cnt
);
  rtc_time_t nxt;
  logic      c_sec, c_min, c_hr, c_date, c_mon;
  logic      cnt_en;

  always_comb begin
    c_sec  = (cnt.sec == 8'h59);
    c_min  = c_sec & (cnt.min == 8'h59);
    c_hr   = c_min & (cnt.hr == 8'h23);
    c_date = c_hr  & (cnt.date == month_len(cnt.mon, cnt.yr));
    c_mon  = c_date & (cnt.mon == 8'h12);
    nxt = cnt;
    if (load) begin
      nxt = load_val;
    end else if (step) begin
      nxt.sec = bcd_step(cnt.sec, 8'h59, 8'h00);
      if (c_sec)  nxt.min  = bcd_step(cnt.min, 8'h59, 8'h00);
      if (c_min)  nxt.hr   = bcd_step(cnt.hr, 8'h23, 8'h00);
      if (c_hr)   nxt.dow  = bcd_step(cnt.dow, 8'h07, 8'h01);
      if (c_hr)   nxt.date = bcd_step(cnt.date, month_len(cnt.mon, cnt.yr), 8'h01);
      if (c_date) nxt.mon  = bcd_step(cnt.mon, 8'h12, 8'h01);
      if (c_mon)  nxt.yr   = bcd_step(cnt.yr, 8'h99, 8'h00);
    end
    cnt_en = load | step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
               hr: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (cnt_en) begin
      cnt <= nxt;
    end
  end

  // R3: a stopped counter holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt));

  // R4: seconds wrap
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt.sec == 8'h59) |=> (cnt.sec == 8'h00));

  // R5: new year
  a_r5_year_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cnt.sec == 8'h59 && cnt.min == 8'h59 && cnt.hr == 8'h23 &&
     cnt.date == 8'h31 && cnt.mon == 8'h12) |=> (cnt.mon == 8'h01 && cnt.date == 8'h01));
endmodule

// File: rtl/rtc_user_buffer.sv
module rtc_user_buffer
  import rtc_regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic                cp_en,
  input  logic [NREG*DW-1:0]  cp_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_idx,
  output logic [NREG*DW-1:0]  regs,
  output logic [DW-1:0]       rd_data
);
  for (genvar g = 0; g < NREG; g++) begin : g_byte
    localparam logic [DW-1:0] MASK = field_mask(g);
    localparam logic [DW-1:0] RST  = reset_byte(g);
    logic          hit, en;
    logic [DW-1:0] d, q;

    always_comb begin
      hit = wr_en && (wr_idx == AW'(g));
      en  = hit | cp_en;
      if (hit) d = wr_data;
      else     d = (q & ~MASK) | (cp_data[g*DW +: DW] & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (en) q <= d;
    end

    assign regs[g*DW +: DW] = q;

    // R11: the host value wins over a simultaneous refresh
    a_r11_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cp_en && wr_idx == AW'(g)) |=> (q == $past(wr_data)));
  end

  logic [DW-1:0] rd_nxt;
  always_comb rd_nxt = regs[rd_idx*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  // R1: read data holds without a read
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R6: nothing moves without a write or a refresh
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cp_en) |=> $stable(regs));
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic          cs,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam logic [TW-1:0] TMASK = time_mask();

  logic [NREG*DW-1:0] regs;
  rtc_time_t          cnt, load_val;
  logic               host_wr, host_rd;
  logic               hold_frz, set_frz, osc_stop;
  logic               run_tick, set_release;
  logic               upd_go, upd_go_d;

  always_comb begin
    host_wr     = cs & we;
    host_rd     = cs & ~we;
    set_frz     = regs[CTL_SET_BIT];
    hold_frz    = regs[CTL_HOLD_BIT];
    osc_stop    = regs[DW + OSC_STOP_BIT];
    run_tick    = sec_tick & ~osc_stop;
    set_release = host_wr && (addr == OFS_CTRL) && !wdata[CTL_SET_BIT] && set_frz;
    load_val    = rtc_time_t'(regs[NREG*DW-1:DW] & TMASK);
    upd_go_d    = run_tick & ~hold_frz & ~set_frz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_go <= 1'b0;
    else        upd_go <= upd_go_d;
  end

  rtc_time_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (run_tick),
    .load     (set_release),
    .load_val (load_val),
    .cnt      (cnt)
  );

  rtc_user_buffer u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr),
    .wr_idx  (addr),
    .wr_data (wdata),
    .cp_en   (upd_go),
    .cp_data ({cnt, {DW{1'b0}}}),
    .rd_en   (host_rd),
    .rd_idx  (addr),
    .regs    (regs),
    .rd_data (rdata)
  );

  // R7 and R9: a freeze present at the tick edge stops the copy
  a_r7_freeze_blocks_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_frz || set_frz) |=> !upd_go);

  // R3: no refresh while the oscillator is stopped
  a_r3_stopped_no_copy: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |=> !upd_go);

  // R9: releasing set freeze loads the visible time into the counter
  a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    set_release |=> (cnt == $past(load_val)));
endmodule

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       cs = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rtc_regbank uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    @(negedge clk); cs = 0; d = rdata;
  endtask

  task automatic expect_byte(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, y);
    wr(0, 8'h80);
    wr(1, s); wr(2, mi); wr(3, h); wr(4, dw); wr(5, dt); wr(6, mo); wr(7, y);
    wr(0, 8'h00);
  endtask

  task automatic t_reset();
    expect_byte("R2 ctrl", 0, 8'h00); expect_byte("R2 sec", 1, 8'h80);
    expect_byte("R2 min", 2, 8'h00);  expect_byte("R2 hr", 3, 8'h00);
    expect_byte("R2 day", 4, 8'h01);  expect_byte("R2 date", 5, 8'h01);
    expect_byte("R2 mon", 6, 8'h01);  expect_byte("R2 yr", 7, 8'h00);
  endtask

  task automatic t_osc_and_carry();
    tick();
    expect_byte("R3 stopped sec", 1, 8'h80);
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    tick();
    expect_byte("R3 restart sec", 1, 8'h59);
    tick();
    expect_byte("R4 sec wrap", 1, 8'h00); expect_byte("R4 min wrap", 2, 8'h00);
    expect_byte("R4 hr wrap", 3, 8'h00);  expect_byte("R4 dow wrap", 4, 8'h01);
    expect_byte("R5 feb28 date", 5, 8'h01); expect_byte("R5 feb28 mon", 6, 8'h03);
    expect_byte("R5 yr kept", 7, 8'h23);
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    tick();
    expect_byte("R5 leap date", 5, 8'h29); expect_byte("R5 leap mon", 6, 8'h02);
    expect_byte("R4 dow step", 4, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick();
    expect_byte("R5 leap end", 5, 8'h01); expect_byte("R5 leap end mon", 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h24);
    tick();
    expect_byte("R5 30-day", 5, 8'h01); expect_byte("R5 30-day mon", 6, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h24);
    tick();
    expect_byte("R5 31-day", 5, 8'h31); expect_byte("R5 31-day mon", 6, 8'h01);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    tick();
    expect_byte("R5 year end date", 5, 8'h01); expect_byte("R5 year end mon", 6, 8'h01);
    expect_byte("R5 year wrap", 7, 8'h00);
  endtask

  task automatic t_hold_freeze();
    set_time(8'h10, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(0, 8'h40);
    for (int i = 0; i < 3; i++) tick();
    expect_byte("R7 frozen sec", 1, 8'h10);
    wr(0, 8'h00);
    tick();
    expect_byte("R7 resumed sec", 1, 8'h14);
  endtask

  task automatic t_freeze_race();
    // freeze written on the tick edge
    @(negedge clk); sec_tick = 1; cs = 1; we = 1; addr = 0; wdata = 8'h40;
    @(negedge clk); sec_tick = 0; cs = 0; we = 0;
    @(negedge clk);
    expect_byte("R8 tick-edge freeze", 1, 8'h15);
    tick();
    expect_byte("R8 frozen after", 1, 8'h15);
    wr(0, 8'h00);
    tick();
    expect_byte("R8 resume", 1, 8'h17);
    // freeze written on the copy edge
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0; cs = 1; we = 1; addr = 0; wdata = 8'h40;
    @(negedge clk); cs = 0; we = 0;
    expect_byte("R8 copy-edge freeze", 1, 8'h18);
    wr(0, 8'h00);
  endtask

  task automatic t_set_freeze();
    wr(0, 8'h80);
    wr(2, 8'h33);
    tick();
    expect_byte("R9 host min kept", 2, 8'h33);
    expect_byte("R9 sec not refreshed", 1, 8'h18);
    wr(0, 8'h00);
    tick();
    expect_byte("R9 loaded sec", 1, 8'h19);
    expect_byte("R9 loaded min", 2, 8'h33);
  endtask

  task automatic t_spare_bits();
    wr(0, 8'h15);
    expect_byte("R10 ctrl spare", 0, 8'h15);
    wr(4, 8'hF8);
    tick();
    expect_byte("R6 R10 day merge", 4, 8'hF9);
    expect_byte("R10 ctrl kept", 0, 8'h15);
    expect_byte("R6 sec refreshed", 1, 8'h20);
  endtask

  task automatic t_write_vs_copy();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0; cs = 1; we = 1; addr = 2; wdata = 8'h45;
    @(negedge clk); cs = 0; we = 0;
    expect_byte("R11 host wins", 2, 8'h45);
    expect_byte("R11 other byte copied", 1, 8'h21);
    tick();
    expect_byte("R11 next refresh", 2, 8'h33);
  endtask

  task automatic t_rdata_hold();
    logic [7:0] v;
    rd(7, v);
    check("R1 year offset", v, 8'h00);
    repeat (3) @(negedge clk);
    check("R1 rdata hold", rdata, 8'h00);
    rd(4, v);
    check("R1 day offset", v, 8'hF9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_osc_and_carry();
    t_months();
    t_hold_freeze();
    t_freeze_race();
    t_set_freeze();
    t_spare_bits();
    t_write_vs_copy();
    t_rdata_hold();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule